// File: doc/BRIEF.md
# Line-Locked Horizontal Blanking Generator

This block produces the horizontal blanking gate applied to the RGB video outputs of a display processor. It runs on the line-locked clock and watches the flyback pulse. Each line, it measures where the centre of the flyback pulse falls, in clocks counted from the previous flyback trailing edge. On the following line it raises a counter-derived blanking gate a programmable number of clocks ahead of that predicted centre. The gate then holds until the flyback trailing edge. The lead is 40 clocks at shift code 0 and grows by 2 clocks per code step.

A second window, the wide blank, is timed from the rising edge of the horizontal drive reference and does not depend on flyback. It lets a picture squeezed horizontally onto a wider tube hide its disturbed edges. The window opens a programmable phase after the reference edge. It stays open for the previous line's normal blanking length plus twice a mode-dependent margin, so it overhangs the normal blanking on both sides. The output is the OR of the counter blanking, the flyback interval and the wide window. It is forced high until one complete flyback pulse has been measured.

Top module: `hblank_gen`

## Requirements
- R1: After reset, `hblank` is 1 and stays 1 until the block is locked. Locking happens on a flyback trailing edge that was preceded by a rising edge, which in turn followed an earlier trailing edge.
- R2: Whenever `flyback` is sampled 1 on a clock edge, `hblank` is 1 after that edge.
- R3: Number the edges of a line k = 0 at the edge that samples the flyback trailing edge and count up from there. Let a be the k of the rising edge in a line and f the k of the next trailing edge. On the following line, counter blanking is 1 from edge k = max(floor((a+f)/2) − (40 + 2·`cb_shift`), 1) to the end of the line.
- R4: Once locked, blanking other than the wide window ends on the edge that samples the flyback trailing edge: `hblank` is 0 after that edge when the wide window is off.
- R5: `cb_shift`, `wide_en`, `wide_phase` and `mode_2fh` are latched only at the trailing-edge sample. A change within a line has no effect until the next line.
- R6: Let j count edges from the one that samples a rising edge of `hdrive_ref` (j = 0 there). The wide window is 1 for 2·`wide_phase` ≤ j < 2·`wide_phase` + N + 2·M. N is the count of line samples on which flyback or counter blanking was 1 over the previous line, and M is the latched margin.
- R7: With the latched `wide_enable` at 0, the wide window never contributes to `hblank`.
- R8: The margin M is 7 clocks with `mode_2fh` = 0 and 4 clocks with `mode_2fh` = 1.
- R9: Before the first rising edge of `hdrive_ref` after reset, the wide window stays closed even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst | input | 1 | Synchronous active-high reset |
| flyback | input | 1 | Horizontal flyback pulse, high during flyback |
| hdrive_ref | input | 1 | Horizontal drive reference pulse; its rising edge times the wide window |
| mode_2fh | input | 1 | 0 selects single line rate, 1 double line rate (picks the wide margin) |
| cb_shift | input | 4 | Counter-blanking lead extension, 2 clocks per step |
| wide_en | input | 1 | Enables the wide blanking window |
| wide_phase | input | 4 | Wide-window delay after the reference edge, 2 clocks per step |
| hblank | output | 1 | Horizontal blanking gate for the RGB outputs |

## Verification
The assertions assume that flyback pulses are at least one clock high and one clock low. They also assume that lines stay shorter than the position counter range, so the measured centre and blanking length never saturate. The stimulus therefore uses lines of 60 to 150 clocks, with the flyback rise 10 to 40 clocks before the line end. Reference pulses last two clocks and lie inside the line. Register fields are changed both at line starts and in mid-line, so the latching at the trailing edge is exercised without ever breaking these assumptions.

// File: rtl/hblank_gen.sv
module hblank_gen #(
  parameter int PW    = 11,
  parameter int CW    = 4,
  parameter int LEAD0 = 40,
  parameter int LSTEP = 2,
  parameter int WSTEP = 2,
  parameter int MAR1  = 7,
  parameter int MAR2  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flyback,
  input  logic          hdrive_ref,
  input  logic          mode_2fh,
  input  logic [CW-1:0] cb_shift,
  input  logic          wide_en,
  input  logic [CW-1:0] wide_phase,
  output logic          hblank
);
  localparam int SW = PW + 2;

  logic          fly_d, ref_d;
  logic          seen_f, has_r, lk, cb;
  logic          armed, wen_r;
  logic [PW-1:0] pos, rpos, cen_r, lead_r, tgt;
  logic [PW-1:0] nbcnt, nb_len, wk, ws_r, mar_r;
  logic [PW:0]   csum;
  logic [SW-1:0] wend;
  logic          wide_on, nb_now;

  wire fall  = fly_d & ~flyback;
  wire rise  = flyback & ~fly_d;
  wire rrise = hdrive_ref & ~ref_d;

  assign csum    = {1'b0, rpos} + {1'b0, pos};
  assign tgt     = (cen_r > lead_r) ? cen_r - lead_r : '0;
  assign nb_now  = cb | fly_d;
  assign wend    = SW'(ws_r) + SW'(nb_len) + (SW'(mar_r) << 1);
  assign wide_on = armed & wen_r & (wk >= ws_r) & (SW'(wk) < wend);
  assign hblank  = ~lk | nb_now | wide_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      fly_d  <= 1'b0;
      pos    <= '0;
      rpos   <= '0;
      seen_f <= 1'b0;
      has_r  <= 1'b0;
      lk     <= 1'b0;
      cen_r  <= '0;
      lead_r <= PW'(LEAD0);
      cb     <= 1'b0;
      nbcnt  <= '0;
      nb_len <= '0;
      wen_r  <= 1'b0;
      ws_r   <= '0;
      mar_r  <= PW'(MAR1);
    end else begin
      fly_d <= flyback;
      if (fall) begin
        pos    <= '0;
        seen_f <= 1'b1;
        if (has_r) lk <= 1'b1;
        cen_r  <= csum[PW:1];
        lead_r <= PW'(LEAD0) + PW'(LSTEP) * PW'(cb_shift);
        cb     <= 1'b0;
        nb_len <= nbcnt + PW'(nb_now);
        nbcnt  <= '0;
        wen_r  <= wide_en;
        ws_r   <= PW'(WSTEP) * PW'(wide_phase);
        mar_r  <= mode_2fh ? PW'(MAR2) : PW'(MAR1);
      end else begin
        if (!(&pos)) pos <= pos + 1'b1;
        if (lk && pos == tgt) cb <= 1'b1;
        if (!(&nbcnt)) nbcnt <= nbcnt + PW'(nb_now);
      end
      if (rise) begin
        rpos <= pos;
        if (seen_f) has_r <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d <= 1'b0;
      wk    <= '0;
      armed <= 1'b0;
    end else begin
      ref_d <= hdrive_ref;
      if (rrise) begin
        wk    <= '0;
        armed <= 1'b1;
      end else if (!(&wk)) begin
        wk <= wk + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hblank_gen_chk.sv
module hblank_gen_chk #(
  parameter int PW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          flyback,
  input logic          wide_en,
  input logic          hblank,
  input logic          fly_d,
  input logic          lk,
  input logic [PW-1:0] lead_r
);
  logic c_fd, c_sf, c_hr, c_lk;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_fd <= 1'b0;
      c_sf <= 1'b0;
      c_hr <= 1'b0;
      c_lk <= 1'b0;
    end else begin
      c_fd <= flyback;
      if (c_fd && !flyback) begin
        c_sf <= 1'b1;
        if (c_hr) c_lk <= 1'b1;
      end
      if (flyback && !c_fd && c_sf) c_hr <= 1'b1;
    end
  end

  a_r1_blank_until_lock: assert property (@(posedge clk) disable iff (rst)
    !c_lk |-> hblank);

  a_r2_flyback_blanks: assert property (@(posedge clk) disable iff (rst)
    flyback |=> hblank);

  a_r4_ends_on_trailing: assert property (@(posedge clk) disable iff (rst)
    (lk && fly_d && !flyback && !wide_en) |=> !hblank);

  a_r5_lead_held_in_line: assert property (@(posedge clk) disable iff (rst)
    !(fly_d && !flyback) |=> $stable(lead_r));
endmodule

bind hblank_gen hblank_gen_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .flyback(flyback), .wide_en(wide_en),
  .hblank(hblank), .fly_d(fly_d), .lk(lk), .lead_r(lead_r)
);

// File: tb/tb_hblank_gen.sv
`timescale 1ns/1ps
module tb_hblank_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flyback = 1'b0, hdrive_ref = 1'b0, mode_2fh = 1'b0, wide_en = 1'b0;
  logic [3:0] cb_shift = '0, wide_phase = '0;
  logic       hblank;

  int checks = 0, errors = 0;

  int m_fp, m_rp, m_seen, m_hasr, m_lk, m_k, m_rk, m_s;
  int m_cnt, m_nbl, m_wk, m_arm, m_wen, m_ws, m_mar;
  int exp_b, cls;

  always #2.5 clk = ~clk;

  hblank_gen dut (
    .clk(clk), .rst(rst), .flyback(flyback), .hdrive_ref(hdrive_ref),
    .mode_2fh(mode_2fh), .cb_shift(cb_shift), .wide_en(wide_en),
    .wide_phase(wide_phase), .hblank(hblank)
  );

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_reset();
    m_fp = 0; m_rp = 0; m_seen = 0; m_hasr = 0; m_lk = 0; m_k = 0; m_rk = 0;
    m_s = 1; m_cnt = 0; m_nbl = 0; m_wk = 0; m_arm = 0; m_wen = 0; m_ws = 0; m_mar = 7;
  endtask

  // cls: 1 = R1 lock, 2 = R2 flyback, 3 = R3 counter, 6 = R6 wide, 4 = R4 off
  task automatic model_edge(int f, int r, int code, int wen, int ph, int mode);
    int fall, rise, cbx, normx, wx;
    fall = (!f && m_fp) ? 1 : 0;
    rise = (f && !m_fp) ? 1 : 0;
    if (fall) begin
      if (m_hasr) m_lk = 1;
      m_seen = 1;
      m_s   = imax((m_rk + m_k + 1) / 2 - (40 + 2 * code), 1);
      m_nbl = m_cnt;
      m_cnt = 0;
      m_wen = wen;
      m_ws  = 2 * ph;
      m_mar = mode ? 4 : 7;
      m_k   = 0;
    end else begin
      m_k++;
    end
    if (rise) begin
      m_rk = m_k;
      if (m_seen) m_hasr = 1;
    end
    if (r && !m_rp) begin
      m_wk = 0;
      m_arm = 1;
    end else begin
      m_wk++;
    end
    m_rp = r;
    m_fp = f;
    cbx   = (m_lk && !fall && m_k >= m_s) ? 1 : 0;
    normx = (cbx || f) ? 1 : 0;
    m_cnt += normx;
    wx = (m_arm && m_wen && m_wk >= m_ws && m_wk < m_ws + m_nbl + 2 * m_mar) ? 1 : 0;
    exp_b = (!m_lk || normx || wx) ? 1 : 0;
    cls = !m_lk ? 1 : f ? 2 : cbx ? 3 : wx ? 6 : 4;
  endtask

  task automatic check(string tag);
    checks++;
    if (hblank !== exp_b[0]) begin
      errors++;
      $display("FAIL %s (class R%0d) t=%0t: hblank actual %b expected %0d",
               tag, cls, $time, hblank, exp_b);
    end
  endtask

  task automatic run_line(int a, int l, int rofs, int c0, int c1, int w0, int w1,
                          int p0, int p1, int md0, int md1, string tag);
    for (int c = 0; c < l; c++) begin
      int f, r, h;
      h = (c >= l / 2) ? 1 : 0;
      f = (c >= a) ? 1 : 0;
      r = (rofs >= 0 && (c == rofs || c == rofs + 1)) ? 1 : 0;
      flyback    = f[0];
      hdrive_ref = r[0];
      cb_shift   = 4'(h ? c1 : c0);
      wide_en    = h ? w1[0] : w0[0];
      wide_phase = 4'(h ? p1 : p0);
      mode_2fh   = h ? md1[0] : md0[0];
      @(posedge clk);
      model_edge(f, r, int'(cb_shift), int'(wide_en), int'(wide_phase), int'(mode_2fh));
      @(negedge clk);
      check(tag);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    model_reset();
    repeat (4) @(negedge clk);
    checks++;
    if (hblank !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: hblank actual %b expected 1", hblank);
    end
    rst = 1'b0;
    // R1: blanked until one full flyback pulse measured
    repeat (2) run_line(70, 100, -1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R3 / R4: default lead, then maximum lead, then clamp at line start
    repeat (3) run_line(70, 100, -1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    repeat (2) run_line(70, 100, -1, 15, 15, 0, 0, 0, 0, 0, 0, "R3");
    repeat (2) run_line(40, 60, -1, 15, 15, 0, 0, 0, 0, 0, 0, "R3_clamp");
    repeat (2) run_line(80, 120, -1, 5, 5, 0, 0, 0, 0, 0, 0, "R4");
    // R9: enabled but no reference edge yet
    repeat (2) run_line(80, 120, -1, 0, 0, 1, 1, 2, 2, 0, 0, "R9");
    // R6 and R8: wide window in both modes
    repeat (3) run_line(80, 120, 60, 0, 0, 1, 1, 3, 3, 0, 0, "R6");
    repeat (3) run_line(80, 120, 60, 0, 0, 1, 1, 3, 3, 1, 1, "R8");
    repeat (2) run_line(80, 120, 10, 2, 2, 1, 1, 0, 0, 0, 0, "R6_early");
    // R7: reference present, enable off
    repeat (2) run_line(80, 120, 60, 0, 0, 0, 0, 3, 3, 0, 0, "R7");
    // R5: fields changed in mid-line
    repeat (3) run_line(90, 130, 50, 0, 15, 0, 1, 0, 7, 0, 1, "R5");
    repeat (2) run_line(90, 130, 50, 15, 0, 1, 0, 7, 0, 1, 0, "R5");
    // random lines
    for (int i = 0; i < 60; i++) begin
      int l, a, ro;
      l  = 90 + int'($urandom % 60);
      a  = l - 10 - int'($urandom % 30);
      ro = int'($urandom % (l - 3));
      run_line(a, l, ro, int'($urandom % 16), int'($urandom % 16),
               int'($urandom % 2), int'($urandom % 2),
               int'($urandom % 16), int'($urandom % 16),
               int'($urandom % 2), int'($urandom % 2), "RND");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule